// File: doc/BRIEF.md
# Peripheral Security Attribute Controller

This block is a small register file that tells the bus firewall, for each securable peripheral, whether the peripheral may be reached only by secure masters and whether it may be reached only by privileged masters. The two attributes are held in separate registers and driven out as vectors, one bit per peripheral. The block also holds watermark lengths for three memories: two for the flash and one for each of the two RAMs. Each length is stored in units of a per-memory granule and driven out in bytes.

Software programs the block through an APB-style bus that carries a secure qualifier and a privileged qualifier with each transfer. The two attribute registers have different write rules. The watermark registers need a privileged master. Reads are open to every master. One peripheral slot takes its secure attribute from a strap input and cannot be changed by software. Once software sets a sticky lock bit, every attribute and watermark register is frozen until reset. Write attempts made while the lock is set complete normally and raise a one-cycle illegal-access event.

Top module: `periph_sec_ctrl`

## Requirements
- R1: After reset, all attribute bits, all watermark lengths, the lock, the illegal-access event and every register read return zero. The exception is the strap slot's secure bit, which follows the strap.
- R2: The secure-attribute register sits at byte offset 0x04, with bit i for peripheral i. A write changes it only when both psecure_i and ppriv_i are high. Any other write leaves it unchanged.
- R3: The privileged-attribute register sits at offset 0x08, with bit i for peripheral i. A write changes it whenever ppriv_i is high, whatever the value of psecure_i. An unprivileged write leaves it unchanged.
- R4: The strap slot's secure output and its secure-register read bit both equal sec_strap_i at all times. Software writes to that bit have no effect.
- R5: The control register sits at offset 0x00, with the lock at bit 0. Only a write that is both secure and privileged can set the lock, by writing 1 to bit 0. Writing 0 never clears it, and only reset does. Any master can read the lock.
- R6: While the lock is set, writes to offsets 0x04, 0x08, 0x10, 0x14, 0x18 and 0x1C leave every register and output unchanged, whatever the qualifiers.
- R7: illegal_o is high for exactly the one cycle after the access phase of a write to one of the offsets listed in R6 while the lock is set. It is never high at any other time, including for writes to the control register and for reads.
- R8: The watermark registers are the flash unprivileged area (0x10), the flash unprivileged-writable area (0x14), the first RAM (0x18) and the second RAM (0x1C). Each holds a field in bits [W-1:0], with W of 8, 8, 6 and 6. The byte length output equals the field shifted left by 11, 11, 10 and 10. Data bits above W are dropped and read as zero.
- R9: A write to a watermark register takes effect only when ppriv_i is high.
- R10: Attribute bits at or above the peripheral count read as zero. Offset 0x0C, any offset with bits [1:0] not zero, and any offset at or above 0x20 hold nothing and read as zero. Writes to these offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | Write when high |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | 32 | Write data |
| psecure_i | input | 1 | Transfer issued by a secure master |
| ppriv_i | input | 1 | Transfer issued in a privileged context |
| prdata_o | output | 32 | Read data, combinational from the address |
| sec_strap_i | input | 1 | Secure attribute of the strap slot |
| sec_o | output | N_PERIPH | Secure attribute per peripheral |
| priv_o | output | N_PERIPH | Privileged attribute per peripheral |
| lock_o | output | 1 | Configuration lock state |
| illegal_o | output | 1 | One-cycle pulse for a write attempt while locked |
| flash_up_len_o | output | LEN_W | Flash unprivileged area length in bytes |
| flash_uw_len_o | output | LEN_W | Flash unprivileged-writable area length in bytes |
| ram1_up_len_o | output | LEN_W | First RAM unprivileged area length in bytes |
| ram2_up_len_o | output | LEN_W | Second RAM unprivileged area length in bytes |

## Verification
The hardest state to reach is a locked block whose registers hold non-zero values. That state is the only one in which a blocked write could show up as a change. To build it, the bench sweeps every register under all four qualifier combinations with varied data while unlocked. It then tries to set the lock with each weaker qualifier pair before setting it properly. Finally it repeats the whole sweep while locked, toggling the strap throughout and checking both the illegal pulse and every readback after each write.

// File: rtl/psac_pkg.sv
package psac_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NUM_WM = 4;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_SEC    = 3'd1,
    REG_PRIV   = 3'd2,
    REG_HOLE   = 3'd3,
    REG_WM_FUP = 3'd4,
    REG_WM_FUW = 3'd5,
    REG_WM_R1  = 3'd6,
    REG_WM_R2  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/psac_access.sv
module psac_access
  import psac_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic              psecure_i,
  input  logic              ppriv_i,
  input  logic              lock_i,
  output reg_sel_e          sel_o,
  output logic              we_ctrl_o,
  output logic              we_sec_o,
  output logic              we_priv_o,
  output logic [NUM_WM-1:0] we_wm_o,
  output logic              illegal_o
);
  logic hit, wr, lockable;

  assign hit   = (paddr_i[1:0] == 2'b00) && ((paddr_i >> 5) == '0);
  assign sel_o = hit ? reg_sel_e'(paddr_i[4:2]) : REG_HOLE;
  assign wr    = psel_i && penable_i && pwrite_i;

  assign lockable  = (sel_o != REG_CTRL) && (sel_o != REG_HOLE);
  assign we_ctrl_o = wr && (sel_o == REG_CTRL) && psecure_i && ppriv_i;
  assign we_sec_o  = wr && (sel_o == REG_SEC) && psecure_i && ppriv_i && !lock_i;
  assign we_priv_o = wr && (sel_o == REG_PRIV) && ppriv_i && !lock_i;

  for (genvar g = 0; g < NUM_WM; g++) begin : g_wm_we
    assign we_wm_o[g] = wr && (sel_o == reg_sel_e'(3'(4 + g))) && ppriv_i && !lock_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_o <= 1'b0;
    else         illegal_o <= wr && lock_i && lockable;
  end

  // the pulse may only follow an attempt made while the lock was set
  p_illegal_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> lock_i);
endmodule

// File: rtl/psac_attr.sv
module psac_attr #(
  parameter int unsigned N_PERIPH   = 8,
  parameter int unsigned STRAP_SLOT = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_sec_i,
  input  logic                we_priv_i,
  input  logic [N_PERIPH-1:0] wdata_i,
  input  logic                strap_i,
  output logic [N_PERIPH-1:0] sec_o,
  output logic [N_PERIPH-1:0] priv_o
);
  for (genvar g = 0; g < N_PERIPH; g++) begin : g_slot
    if (g == STRAP_SLOT) begin : g_strap
      assign sec_o[g] = strap_i;
    end else begin : g_soft
      logic sec_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       sec_q <= 1'b0;
        else if (we_sec_i) sec_q <= wdata_i[g];
      end
      assign sec_o[g] = sec_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        priv_o <= '0;
    else if (we_priv_i) priv_o <= wdata_i;
  end
endmodule

// File: rtl/psac_wm.sv
module psac_wm #(
  parameter int unsigned FW     = 8,
  parameter int unsigned GRAN   = 11,
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] field_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [FW-1:0] field_q;
  logic          unused_hi;

  assign unused_hi = ^(wdata_i >> FW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   field_q <= '0;
    else if (we_i) field_q <= wdata_i[FW-1:0];
  end

  assign field_o = DATA_W'(field_q);
  // held in granules, expanded to bytes only at the output
  assign len_o   = LEN_W'(field_q) << GRAN;
endmodule

// File: rtl/periph_sec_ctrl.sv
module periph_sec_ctrl
  import psac_pkg::*;
#(
  parameter int unsigned N_PERIPH   = 8,
  parameter int unsigned STRAP_SLOT = 3,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned FLASH_WM_W = 8,
  parameter int unsigned RAM1_WM_W  = 6,
  parameter int unsigned RAM2_WM_W  = 6,
  parameter int unsigned FLASH_GRAN = 11,
  parameter int unsigned RAM1_GRAN  = 10,
  parameter int unsigned RAM2_GRAN  = 10,
  parameter int unsigned LEN_W      = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [ADDR_W-1:0]   paddr_i,
  input  logic [DATA_W-1:0]   pwdata_i,
  input  logic                psecure_i,
  input  logic                ppriv_i,
  output logic [DATA_W-1:0]   prdata_o,
  input  logic                sec_strap_i,
  output logic [N_PERIPH-1:0] sec_o,
  output logic [N_PERIPH-1:0] priv_o,
  output logic                lock_o,
  output logic                illegal_o,
  output logic [LEN_W-1:0]    flash_up_len_o,
  output logic [LEN_W-1:0]    flash_uw_len_o,
  output logic [LEN_W-1:0]    ram1_up_len_o,
  output logic [LEN_W-1:0]    ram2_up_len_o
);
  localparam int unsigned WM_W [NUM_WM] = '{FLASH_WM_W, FLASH_WM_W, RAM1_WM_W, RAM2_WM_W};
  localparam int unsigned WM_G [NUM_WM] = '{FLASH_GRAN, FLASH_GRAN, RAM1_GRAN, RAM2_GRAN};

  reg_sel_e          sel;
  logic              we_ctrl, we_sec, we_priv, lock_q;
  logic [NUM_WM-1:0] we_wm;
  logic [DATA_W-1:0] wm_field [NUM_WM];
  logic [LEN_W-1:0]  wm_len   [NUM_WM];
  logic [2:0]        sel_bits;

  psac_access #(.ADDR_W(ADDR_W)) u_access (
    .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .psecure_i, .ppriv_i,
    .lock_i(lock_q), .sel_o(sel), .we_ctrl_o(we_ctrl), .we_sec_o(we_sec),
    .we_priv_o(we_priv), .we_wm_o(we_wm), .illegal_o
  );

  psac_attr #(.N_PERIPH(N_PERIPH), .STRAP_SLOT(STRAP_SLOT)) u_attr (
    .clk_i, .rst_ni, .we_sec_i(we_sec), .we_priv_i(we_priv),
    .wdata_i(pwdata_i[N_PERIPH-1:0]), .strap_i(sec_strap_i), .sec_o, .priv_o
  );

  for (genvar g = 0; g < NUM_WM; g++) begin : g_wm
    psac_wm #(.FW(WM_W[g]), .GRAN(WM_G[g]), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_wm (
      .clk_i, .rst_ni, .we_i(we_wm[g]), .wdata_i(pwdata_i),
      .field_o(wm_field[g]), .len_o(wm_len[g])
    );
  end

  // set-only; cleared by reset alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lock_q <= 1'b0;
    else if (we_ctrl && pwdata_i[0]) lock_q <= 1'b1;
  end

  assign lock_o         = lock_q;
  assign flash_up_len_o = wm_len[0];
  assign flash_uw_len_o = wm_len[1];
  assign ram1_up_len_o  = wm_len[2];
  assign ram2_up_len_o  = wm_len[3];
  assign sel_bits       = sel;

  always_comb begin
    unique case (sel)
      REG_CTRL: prdata_o = DATA_W'(lock_q);
      REG_SEC:  prdata_o = DATA_W'(sec_o);
      REG_PRIV: prdata_o = DATA_W'(priv_o);
      REG_HOLE: prdata_o = '0;
      default:  prdata_o = wm_field[sel_bits[1:0]];
    endcase
  end

  logic bus_wr;
  logic [N_PERIPH-1:0] soft_mask;
  assign bus_wr    = psel_i && penable_i && pwrite_i;
  assign soft_mask = ~(N_PERIPH'(1) << STRAP_SLOT);

  p_sec_guard_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr && paddr_i == ADDR_W'(4) && !(psecure_i && ppriv_i))
      |=> $stable(sec_o & soft_mask));

  p_priv_guard_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr && paddr_i == ADDR_W'(8) && !ppriv_i) |=> $stable(priv_o));

  p_lock_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);

  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> ($stable(priv_o) && $stable(sec_o & soft_mask) &&
                $stable(flash_up_len_o) && $stable(flash_uw_len_o) &&
                $stable(ram1_up_len_o) && $stable(ram2_up_len_o)));

  p_wm_guard_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr && !ppriv_i) |=> ($stable(flash_up_len_o) && $stable(flash_uw_len_o) &&
                              $stable(ram1_up_len_o) && $stable(ram2_up_len_o)));
endmodule

// File: tb/test_periph_sec_ctrl.sv
module test_periph_sec_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0, psecure = 0, ppriv = 0, strap = 0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  sec, priv;
  logic        lock, illegal;
  logic [31:0] len_fup, len_fuw, len_r1, len_r2;

  int tests = 0, fails = 0, cycles = 0;

  logic [7:0]  m_sec, m_priv;
  logic        m_lock;
  logic [31:0] m_wm [4];
  logic        last_ill;
  localparam logic [31:0] WMASK [4] = '{32'hFF, 32'hFF, 32'h3F, 32'h3F};
  localparam int          GR    [4] = '{11, 11, 10, 10};

  periph_sec_ctrl i_periph_sec_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .psecure_i(psecure), .ppriv_i(ppriv),
    .prdata_o(prdata), .sec_strap_i(strap), .sec_o(sec), .priv_o(priv), .lock_o(lock),
    .illegal_o(illegal), .flash_up_len_o(len_fup), .flash_uw_len_o(len_fuw),
    .ram1_up_len_o(len_r1), .ram2_up_len_o(len_r2)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [4:0] a, input logic [31:0] d, input bit s, input bit p);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; psecure = s; ppriv = p;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    last_ill = illegal;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a; psecure = 0; ppriv = 0;
    @(negedge clk);
    penable = 1;
    d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
    chk(illegal == 1'b0, "R7 read pulse", 32'(illegal), 32'h0);
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [31:0] d, input bit s, input bit p);
    bit exp_ill;
    exp_ill = m_lock && (a inside {5'h04, 5'h08, 5'h10, 5'h14, 5'h18, 5'h1C});
    if (!m_lock) begin
      case (a)
        5'h04: if (s && p) m_sec = d[7:0] & 8'hF7;
        5'h08: if (p) m_priv = d[7:0];
        5'h10, 5'h14, 5'h18, 5'h1C: if (p) m_wm[(a - 5'h10) >> 2] = d & WMASK[(a - 5'h10) >> 2];
        default: ;
      endcase
    end
    if (a == 5'h00 && s && p && d[0]) m_lock = 1'b1;
    apb_write(a, d, s, p);
    chk(last_ill == exp_ill, "R7 illegal pulse", 32'(last_ill), 32'(exp_ill));
    @(negedge clk);
    chk(illegal == 1'b0, "R7 one cycle", 32'(illegal), 32'h0);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] rd;
    logic [7:0]  exp_sec;
    exp_sec = m_sec | (8'(strap) << 3);
    chk(sec == exp_sec, {tag, " R2/R4 sec_o"}, 32'(sec), 32'(exp_sec));
    chk(priv == m_priv, {tag, " R3 priv_o"}, 32'(priv), 32'(m_priv));
    chk(lock == m_lock, {tag, " R5 lock_o"}, 32'(lock), 32'(m_lock));
    chk(len_fup == (m_wm[0] << GR[0]), {tag, " R8 flash up"}, len_fup, m_wm[0] << GR[0]);
    chk(len_fuw == (m_wm[1] << GR[1]), {tag, " R8 flash uw"}, len_fuw, m_wm[1] << GR[1]);
    chk(len_r1 == (m_wm[2] << GR[2]), {tag, " R8 ram1"}, len_r1, m_wm[2] << GR[2]);
    chk(len_r2 == (m_wm[3] << GR[3]), {tag, " R8 ram2"}, len_r2, m_wm[3] << GR[3]);
    apb_read(5'h00, rd); chk(rd == 32'(m_lock), {tag, " R5 lock read"}, rd, 32'(m_lock));
    apb_read(5'h04, rd); chk(rd == 32'(exp_sec), {tag, " R4/R10 sec read"}, rd, 32'(exp_sec));
    apb_read(5'h08, rd); chk(rd == 32'(m_priv), {tag, " R10 priv read"}, rd, 32'(m_priv));
    for (int i = 0; i < 4; i++) begin
      apb_read(5'(5'h10 + 4 * i), rd);
      chk(rd == m_wm[i], {tag, " R8 wm read"}, rd, m_wm[i]);
    end
    apb_read(5'h0C, rd); chk(rd == 0, {tag, " R10 hole read"}, rd, 32'h0);
    apb_read(5'h06, rd); chk(rd == 0, {tag, " R10 misaligned read"}, rd, 32'h0);
  endtask

  task automatic sweep(input string tag);
    logic [31:0] d;
    for (int q = 0; q < 4; q++) begin
      for (int k = 0; k < 5; k++) begin
        d = 32'h9E37_79B9 * 32'(k + 1 + q * 7);
        strap = d[5];
        do_wr(5'h04, d, q[1], q[0]);
        do_wr(5'h08, ~d, q[1], q[0]);
        do_wr(5'h10, d, q[1], q[0]);
        do_wr(5'h14, d >> 3, q[1], q[0]);
        do_wr(5'h18, ~d, q[1], q[0]);
        do_wr(5'h1C, d >> 7, q[1], q[0]);
        do_wr(5'h0C, 32'hFFFF_FFFF, q[1], q[0]);
        do_wr(5'h06, 32'hFFFF_FFFF, q[1], q[0]);
        check_all(tag);
      end
    end
  endtask

  initial begin
    m_sec = '0; m_priv = '0; m_lock = 0; last_ill = 0;
    for (int i = 0; i < 4; i++) m_wm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(illegal == 0, "R1 illegal reset", 32'(illegal), 32'h0);
    check_all("R1 reset");
    strap = 1; @(negedge clk);
    check_all("R4 strap high");

    sweep("unlocked");

    // all-ones to every attribute with full rights: strap slot and high bits must not follow
    do_wr(5'h04, 32'hFFFF_FFFF, 1, 1);
    strap = 0;
    do_wr(5'h08, 32'hFFFF_FFFF, 0, 1);
    check_all("R4/R10 all ones");

    // weaker attempts at the lock
    do_wr(5'h00, 32'h0, 1, 1); check_all("R5 write zero");
    do_wr(5'h00, 32'h1, 0, 1); check_all("R5 nonsecure");
    do_wr(5'h00, 32'h1, 1, 0); check_all("R5 unprivileged");
    do_wr(5'h00, 32'h1, 0, 0); check_all("R5 neither");
    do_wr(5'h00, 32'h1, 1, 1); check_all("R5 set");

    sweep("R6 locked");
    do_wr(5'h00, 32'h0, 1, 1); check_all("R5 no clear");
    strap = ~strap; @(negedge clk);
    check_all("R4 strap while locked");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule